// File: doc/BRIEF.md
# Vector Predicate Mask Generator

This block turns a compact predicate selector into a per-element enable mask for a vector operation of up to 64 elements. An instruction supplies a one-bit mask kind and one 3-bit mask code for the destination side. A twin-predicated instruction also supplies a second code for the source side. Both codes share the same kind. In integer kind, the mask is taken from one of three 64-bit register values, either as stored or inverted, or it is a single enabled element chosen by the first register's value. In condition kind, each element tests one flag of a 4-bit condition field. The condition fields are walked upward from field 48 and wrap modulo 64.

The caller presents the register values, the 64 condition fields and the vector length together with a valid strobe. One cycle later both masks appear on registered outputs, qualified by an output valid pulse. Every mask bit at or above the vector length is forced to zero. Reading the register files and executing the elements are left to the surrounding pipeline.

Top module: `pred_mask_gen`

## Requirements
- R1: `kind_i`=0 decodes both codes as integer predicates and `kind_i`=1 decodes both as condition predicates. One kind applies to the destination and source codes alike.
- R2: In integer kind, code 000 enables every element below the vector length.
- R3: In integer kind, code 001 enables only element i where i equals `reg_a_i`. A `reg_a_i` value of 64 or more gives an all-zero mask.
- R4: In integer kind, codes 01x read `reg_a_i`, codes 10x read `reg_b_i` and codes 11x read `reg_c_i`. An even code enables element i when bit i of the register is 1. An odd code enables element i when that bit is 0.
- R5: In condition kind, field k is `cond_i[4k+3:4k]`, with bit 3 = less-than, bit 2 = greater-than, bit 1 = equal and bit 0 = overflow/unordered. Codes 00x test less-than, 01x greater-than, 10x equal and 11x overflow/unordered. An even code enables on a set flag and an odd code on a clear flag.
- R6: Element i reads condition field (48 + i) mod 64, so element 15 reads field 63 and element 16 reads field 0.
- R7: `src_code_i` uses the same encoding as `dst_code_i` and drives `src_mask_o` independently of it.
- R8: Mask bits at positions at or above `vlen_i` are 0. `vlen_i`=0 gives empty masks and `vlen_i`>=64 clips nothing.
- R9: A `valid_i` high at a clock edge makes `valid_o` high for the next cycle, with both masks computed from the inputs of that edge. Without `valid_i`, `valid_o` is low and both masks hold their values.
- R10: While `rst_ni` is low, `valid_o` and both masks are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Strobe: inputs present a request |
| kind_i | input | 1 | 0 integer predication, 1 condition predication |
| dst_code_i | input | 3 | Destination mask code |
| src_code_i | input | 3 | Source mask code (twin predication) |
| reg_a_i | input | 64 | First mask register value |
| reg_b_i | input | 64 | Second mask register value |
| reg_c_i | input | 64 | Third mask register value |
| cond_i | input | 256 | 64 condition fields, 4 bits each |
| vlen_i | input | 7 | Vector length, 0 to 64 |
| valid_o | output | 1 | Masks updated this cycle |
| dst_mask_o | output | 64 | Destination element enables |
| src_mask_o | output | 64 | Source element enables |

## Verification
The assertions assume that `valid_i` stays low while reset is applied. They also assume that the inputs are steady around the capturing edge, so the previous cycle's `vlen_i` and codes describe the captured request. The bench meets these assumptions by holding `valid_i` low through reset and by changing every input only on the falling clock edge. The vector-length and one-hot properties hold for any register values, so the bench applies random and edge-case register contents freely. These include one-hot indices of 0, 63, 64 and values far out of range.

// File: rtl/pred_pkg.sv
package pred_pkg;
  localparam int unsigned FLD_W  = 4;
  // flag positions inside one condition field
  localparam int unsigned LT_POS = 3;
  localparam int unsigned GT_POS = 2;
  localparam int unsigned EQ_POS = 1;
  localparam int unsigned SO_POS = 0;
  localparam int unsigned CODE_W = 3;

  typedef enum logic [1:0] {
    SEL_FIXED = 2'b00,
    SEL_REG_A = 2'b01,
    SEL_REG_B = 2'b10,
    SEL_REG_C = 2'b11
  } int_sel_e;
endpackage

// File: rtl/pred_int_mask.sv
module pred_int_mask
  import pred_pkg::*;
#(
  parameter int unsigned NUM_ELEM = 64,
  parameter int unsigned REG_W    = 64
) (
  input  logic [CODE_W-1:0]   code_i,
  input  logic [REG_W-1:0]    reg_a_i,
  input  logic [REG_W-1:0]    reg_b_i,
  input  logic [REG_W-1:0]    reg_c_i,
  output logic [NUM_ELEM-1:0] mask_o
);
  logic [NUM_ELEM-1:0] bits_a, bits_b, bits_c, hot;
  logic [NUM_ELEM-1:0] raw;

  for (genvar i = 0; i < NUM_ELEM; i++) begin : g_el
    if (i < REG_W) begin : g_in
      assign bits_a[i] = reg_a_i[i];
      assign bits_b[i] = reg_b_i[i];
      assign bits_c[i] = reg_c_i[i];
    end else begin : g_out
      assign bits_a[i] = 1'b0;
      assign bits_b[i] = 1'b0;
      assign bits_c[i] = 1'b0;
    end
    // full-width compare: out-of-range index matches no element
    assign hot[i] = (reg_a_i == REG_W'(i));
  end

  always_comb begin
    unique case (int_sel_e'(code_i[2:1]))
      SEL_REG_A: raw = bits_a;
      SEL_REG_B: raw = bits_b;
      SEL_REG_C: raw = bits_c;
      default:   raw = code_i[0] ? hot : '1;
    endcase
    if (code_i[2:1] == SEL_FIXED) mask_o = raw;
    else                          mask_o = code_i[0] ? ~raw : raw;
  end
endmodule

// File: rtl/pred_cond_mask.sv
module pred_cond_mask
  import pred_pkg::*;
#(
  parameter int unsigned NUM_ELEM = 64,
  parameter int unsigned NUM_FLD  = 64,
  parameter int unsigned BASE_FLD = 48
) (
  input  logic [CODE_W-1:0]        code_i,
  input  logic [NUM_FLD*FLD_W-1:0] cond_i,
  output logic [NUM_ELEM-1:0]      mask_o
);
  for (genvar i = 0; i < NUM_ELEM; i++) begin : g_el
    localparam int unsigned IDX = (BASE_FLD + i) % NUM_FLD;
    logic [FLD_W-1:0] fld;
    logic             flag;
    assign fld = cond_i[IDX*FLD_W +: FLD_W];
    always_comb begin
      unique case (code_i[2:1])
        2'b00:   flag = fld[LT_POS];
        2'b01:   flag = fld[GT_POS];
        2'b10:   flag = fld[EQ_POS];
        default: flag = fld[SO_POS];
      endcase
    end
    assign mask_o[i] = flag ^ code_i[0];
  end
endmodule

// File: rtl/pred_len_clip.sv
module pred_len_clip #(
  parameter int unsigned NUM_ELEM = 64,
  parameter int unsigned VL_W     = $clog2(NUM_ELEM + 1)
) (
  input  logic [VL_W-1:0]     vlen_i,
  output logic [NUM_ELEM-1:0] keep_o
);
  for (genvar i = 0; i < NUM_ELEM; i++) begin : g_el
    assign keep_o[i] = (vlen_i > VL_W'(i));
  end
endmodule

// File: rtl/pred_mask_gen.sv
module pred_mask_gen
  import pred_pkg::*;
#(
  parameter int unsigned NUM_ELEM = 64,
  parameter int unsigned REG_W    = 64,
  parameter int unsigned NUM_FLD  = 64,
  parameter int unsigned BASE_FLD = 48,
  parameter int unsigned VL_W     = $clog2(NUM_ELEM + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic                     kind_i,
  input  logic [CODE_W-1:0]        dst_code_i,
  input  logic [CODE_W-1:0]        src_code_i,
  input  logic [REG_W-1:0]         reg_a_i,
  input  logic [REG_W-1:0]         reg_b_i,
  input  logic [REG_W-1:0]         reg_c_i,
  input  logic [NUM_FLD*FLD_W-1:0] cond_i,
  input  logic [VL_W-1:0]          vlen_i,
  output logic                     valid_o,
  output logic [NUM_ELEM-1:0]      dst_mask_o,
  output logic [NUM_ELEM-1:0]      src_mask_o
);
  localparam int unsigned LANES = 2;

  logic [CODE_W-1:0]   code   [LANES];
  logic [NUM_ELEM-1:0] mask_d [LANES];
  logic [NUM_ELEM-1:0] mask_q [LANES];
  logic [NUM_ELEM-1:0] keep;
  logic                valid_q;

  assign code[0] = dst_code_i;
  assign code[1] = src_code_i;

  pred_len_clip #(.NUM_ELEM(NUM_ELEM), .VL_W(VL_W)) u_clip (
    .vlen_i (vlen_i),
    .keep_o (keep)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [NUM_ELEM-1:0] int_m, cnd_m;

    pred_int_mask #(.NUM_ELEM(NUM_ELEM), .REG_W(REG_W)) u_int (
      .code_i  (code[l]),
      .reg_a_i (reg_a_i),
      .reg_b_i (reg_b_i),
      .reg_c_i (reg_c_i),
      .mask_o  (int_m)
    );

    pred_cond_mask #(.NUM_ELEM(NUM_ELEM), .NUM_FLD(NUM_FLD),
                     .BASE_FLD(BASE_FLD)) u_cnd (
      .code_i (code[l]),
      .cond_i (cond_i),
      .mask_o (cnd_m)
    );

    assign mask_d[l] = (kind_i ? cnd_m : int_m) & keep;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      mask_q[l] <= '0;
      else if (valid_i) mask_q[l] <= mask_d[l];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= valid_i;
  end

  assign valid_o    = valid_q;
  assign dst_mask_o = mask_q[0];
  assign src_mask_o = mask_q[1];
endmodule

// File: rtl/pred_mask_gen_chk.sv
module pred_mask_gen_chk #(
  parameter int unsigned NUM_ELEM = 64,
  parameter int unsigned VL_W     = 7
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                valid_i,
  input logic                kind_i,
  input logic [2:0]          dst_code_i,
  input logic [VL_W-1:0]     vlen_i,
  input logic                valid_o,
  input logic [NUM_ELEM-1:0] dst_mask_o,
  input logic [NUM_ELEM-1:0] src_mask_o
);
  // R9
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  // R9
  hold_masks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(dst_mask_o) && $stable(src_mask_o)));

  // R8
  len_clip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (((dst_mask_o >> $past(vlen_i)) == '0) &&
                 ((src_mask_o >> $past(vlen_i)) == '0)));

  // R2
  all_on_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !kind_i && dst_code_i == 3'b000) |=>
      ($countones(dst_mask_o) ==
       (($past(vlen_i) >= VL_W'(NUM_ELEM)) ? NUM_ELEM : int'($past(vlen_i)))));

  // R3
  one_hot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !kind_i && dst_code_i == 3'b001) |=> $onehot0(dst_mask_o));

  // R10
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_clear_chk: assert (!valid_o && dst_mask_o == '0 && src_mask_o == '0);
    end
  end
endmodule

bind pred_mask_gen pred_mask_gen_chk #(.NUM_ELEM(NUM_ELEM), .VL_W(VL_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .kind_i     (kind_i),
  .dst_code_i (dst_code_i),
  .vlen_i     (vlen_i),
  .valid_o    (valid_o),
  .dst_mask_o (dst_mask_o),
  .src_mask_o (src_mask_o)
);

// File: tb/tb_pred_mask_gen.sv
module tb_pred_mask_gen;
  localparam int CLK_PERIOD = 10;

  logic         clk = 0;
  logic         rst_n = 0;
  logic         valid = 0;
  logic         kind = 0;
  logic [2:0]   dcode = 0, scode = 0;
  logic [63:0]  ra = 0, rb = 0, rc = 0;
  logic [255:0] cond = 0;
  logic [6:0]   vlen = 0;
  logic         vout;
  logic [63:0]  dmask, smask;

  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pred_mask_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .kind_i(kind),
    .dst_code_i(dcode), .src_code_i(scode),
    .reg_a_i(ra), .reg_b_i(rb), .reg_c_i(rc),
    .cond_i(cond), .vlen_i(vlen),
    .valid_o(vout), .dst_mask_o(dmask), .src_mask_o(smask)
  );

  function automatic logic [63:0] model(input logic k, input logic [2:0] c,
      input logic [63:0] a, input logic [63:0] b, input logic [63:0] r3,
      input logic [255:0] cf, input int len);
    logic [63:0] m = '0;
    for (int i = 0; i < 64; i++) begin
      logic bit_v;
      if (!k) begin
        if (c == 3'd0)      bit_v = 1'b1;
        else if (c == 3'd1) bit_v = (a == 64'(i));
        else begin
          logic [63:0] r;
          r = (c[2:1] == 2'd1) ? a : (c[2:1] == 2'd2) ? b : r3;
          bit_v = r[i] ^ c[0];
        end
      end else begin
        int fi;
        logic [3:0] f;
        fi = (48 + i) % 64;
        f = cf[fi*4 +: 4];
        bit_v = f[3 - int'(c[2:1])] ^ c[0];
      end
      m[i] = (i < len) ? bit_v : 1'b0;
    end
    return m;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run_one(input string req);
    logic [63:0] ed, es;
    ed = model(kind, dcode, ra, rb, rc, cond, int'(vlen));
    es = model(kind, scode, ra, rb, rc, cond, int'(vlen));
    valid = 1;
    @(posedge clk); #1;
    check({req, " valid_o R9"}, {63'd0, vout}, 64'd1);
    check({req, " dst"}, dmask, ed);
    check({req, " src R7"}, smask, es);
    @(negedge clk);
    valid = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R10
    check("R10 valid", {63'd0, vout}, 64'd0);
    check("R10 dst", dmask, 64'd0);
    check("R10 src", smask, 64'd0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 R2 R4 R5 R7: every kind and code pair
    for (int p = 0; p < 3; p++) begin
      ra = {$urandom, $urandom}; rb = {$urandom, $urandom}; rc = {$urandom, $urandom};
      for (int w = 0; w < 8; w++) cond[w*32 +: 32] = $urandom;
      if (p == 1) ra = 64'd17;
      vlen = (p == 2) ? 7'd40 : 7'd64;
      for (int k = 0; k < 2; k++)
        for (int d = 0; d < 8; d++)
          for (int s = 0; s < 8; s++) begin
            kind = k[0]; dcode = d[2:0]; scode = s[2:0];
            run_one(k ? "R1 R5 cond" : "R1 R2 R3 R4 int");
          end
    end

    // R3 one-hot edges including out-of-range values
    kind = 0; dcode = 3'd1; scode = 3'd0; vlen = 7'd64;
    foreach (ra[j]) ; // no-op
    ra = 64'd0;    run_one("R3 idx0");
    ra = 64'd63;   run_one("R3 idx63");
    ra = 64'd64;   run_one("R3 idx64");
    ra = 64'd1000; run_one("R3 big");
    ra = 64'h8000_0000_0000_0005; run_one("R3 high bit");

    // R6 wrap: single set LT flag in field 63 and field 0
    kind = 1; dcode = 3'd0; scode = 3'd1; cond = '0;
    cond[63*4 + 3] = 1'b1; cond[0*4 + 3] = 1'b1;
    run_one("R6 wrap");
    check("R6 dst exact", dmask, 64'h0000_0000_0001_8000);
    cond = '0; cond[48*4 + 3] = 1'b1;
    run_one("R6 base field");
    check("R6 element0", dmask, 64'h1);

    // R8 vector length sweep
    kind = 0; dcode = 3'd0; scode = 3'd3; ra = {$urandom, $urandom};
    for (int v = 0; v < 128; v += 3) begin
      vlen = v[6:0];
      run_one("R8 vlen");
    end
    vlen = 7'd127; run_one("R8 vlen max");

    // R9 hold: change inputs with valid low
    begin
      logic [63:0] hd, hs;
      hd = dmask; hs = smask;
      kind = 1; dcode = 3'd6; scode = 3'd7; cond = {8{32'hdead_beef}}; vlen = 7'd64;
      repeat (3) @(posedge clk);
      #1;
      check("R9 hold valid_o", {63'd0, vout}, 64'd0);
      check("R9 hold dst", dmask, hd);
      check("R9 hold src", smask, hs);
      @(negedge clk);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule